// File: doc/BRIEF.md
# Register-Mapped 128-bit Memory Test Agent

This block gives a host with a 32-bit register bus access to a memory whose lines are 128 bits wide. The host loads an address and four 32-bit write words, then starts a transaction through a control register. While the transaction is in flight a busy flag is set, and the host polls it. When a read finishes, all four 32-bit words of the addressed line can be read from the read-data registers. When a write finishes, all four write words have been stored into the line.

Each transaction moves a whole line. The line address is the host address with its low four bits dropped. A host that wants to change only 64 bits must first read the line and copy the half it keeps into the write registers, then write the line back. The memory here is a behavioural array of 128-bit lines that reset clears to zero.

Top module: `mem_test_agent`

## Requirements
- R1: After reset, every register reads as zero, busy is low, and every memory line reads as zero.
- R2: The line index is bits [11:4] of the address-low register at offset 0x00. Bits [3:0] are ignored. The address-high register at offset 0x08 is stored and reads back, but it does not select a line.
- R3: Writing the control register at offset 0x90 with enable (bit 0) and start (bit 1) both set, while busy is low, raises busy on the next cycle. Busy stays high for exactly 4 cycles and then falls. The start bit reads back as 1 while busy is high and as 0 after the transaction ends.
- R4: A control write with start set and enable clear does not begin a transaction, and busy stays low.
- R5: When the write bit (control bit 2) is set, the transaction stores all four write words into the line. Word i sits at offset 0x10 + 0x10*(i>>1) + 4*(i&1), which gives 0x10, 0x14, 0x20 and 0x24, and occupies line bits [32i+31:32i].
- R6: When the write bit is clear, the transaction loads the line into the read words at 0x18, 0x1C, 0x28 and 0x2C, using the same word-to-bit placement as R5. The read words change only when a read transaction completes.
- R7: A control write while busy is high is ignored. It neither lengthens the transaction in progress nor starts another one.
- R8: Write-data registers written while busy is high do not change the line that the transaction in progress stores.
- R9: The control register reads back enable in bit 0, start in bit 1, write in bit 2 and busy in bit 3. The write-data and address registers read back their last value. Offsets that are not mapped read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| busy | output | 1 | Transaction in progress |

## Verification
Two events can coincide in one cycle: a host register write landing while a transaction is in flight, and that transaction's commit. The bench provokes this by writing a second start, and also new write-data words, during the busy window. It then judges that busy ends exactly 4 cycles after the first start, that no second transaction follows, and that the stored line matches the data present at the first start. Random full-line writes and read-backs against a bench model cover the address slicing and the word placement.

// File: rtl/mta_pkg.sv
package mta_pkg;
    localparam int WORD_W = 32;
    localparam int WORDS  = 4;
    localparam int LINE_W = WORD_W * WORDS;

    localparam logic [7:0] OFF_ADDR_LO = 8'h00;
    localparam logic [7:0] OFF_ADDR_HI = 8'h08;
    localparam logic [7:0] OFF_WR_BASE = 8'h10;
    localparam logic [7:0] OFF_RD_BASE = 8'h18;
    localparam logic [7:0] OFF_CTRL    = 8'h90;

    localparam int CTL_EN   = 0;
    localparam int CTL_GO   = 1;
    localparam int CTL_WR   = 2;
    localparam int CTL_BUSY = 3;

    function automatic logic [7:0] word_off(input logic [7:0] base, input int i);
        return base + 8'(16 * (i >> 1)) + 8'(4 * (i & 1));
    endfunction
endpackage

// File: rtl/mta_seq.sv
module mta_seq #(
    parameter int BUSY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        done = s_q.busy && (s_q.cnt == '0);
        if (done) begin
            s_d.busy = 1'b0;
        end else if (s_q.busy) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end else if (launch) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CW'(BUSY_CYCLES - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
endmodule

// File: rtl/mta_line_store.sv
module mta_line_store #(
    parameter int LINE_W = 128,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LINE_W-1:0] wline,
    output logic [LINE_W-1:0] rline
);
    localparam int DEPTH = 1 << IDX_W;

    logic [LINE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[idx] <= wline;
        end
    end

    assign rline = mem_q[idx];
endmodule

// File: rtl/mem_test_agent.sv
module mem_test_agent
    import mta_pkg::*;
#(
    parameter int BUSY_CYCLES = 4,
    parameter int IDX_W       = 8,
    parameter int IDX_LSB     = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        busy
);
    typedef struct packed {
        logic [WORD_W-1:0]            addr_lo;
        logic [WORD_W-1:0]            addr_hi;
        logic [WORDS-1:0][WORD_W-1:0] wr;
        logic [WORDS-1:0][WORD_W-1:0] rd;
        logic                         en;
        logic                         wsel;
        logic                         start;
        logic [IDX_W-1:0]             idx;
        logic [LINE_W-1:0]            snap;
        logic                         snap_wr;
    } regs_t;

    regs_t r_d, r_q;
    logic launch, done, mem_we;
    logic [LINE_W-1:0] rline;
    logic [LINE_W-1:0] rd_line;

    mta_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy), .done(done)
    );

    mta_line_store #(.LINE_W(LINE_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .idx(r_q.idx),
        .wline(r_q.snap), .rline(rline)
    );

    always_comb begin
        r_d    = r_q;
        launch = bus_wr && (bus_addr == OFF_CTRL) && !busy
                 && bus_wdata[CTL_EN] && bus_wdata[CTL_GO];
        if (bus_wr) begin
            if (bus_addr == OFF_ADDR_LO) r_d.addr_lo = bus_wdata;
            if (bus_addr == OFF_ADDR_HI) r_d.addr_hi = bus_wdata;
            for (int i = 0; i < WORDS; i++) begin
                if (bus_addr == word_off(OFF_WR_BASE, i)) r_d.wr[i] = bus_wdata;
            end
            if (bus_addr == OFF_CTRL && !busy) begin
                r_d.en   = bus_wdata[CTL_EN];
                r_d.wsel = bus_wdata[CTL_WR];
            end
        end
        if (launch) begin
            r_d.start   = 1'b1;
            r_d.idx     = r_q.addr_lo[IDX_LSB +: IDX_W];
            r_d.snap    = r_q.wr;
            r_d.snap_wr = bus_wdata[CTL_WR];
        end
        if (done) begin
            r_d.start = 1'b0;
            if (!r_q.snap_wr) r_d.rd = rline;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mem_we  = done && r_q.snap_wr;
    assign rd_line = r_q.rd;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFF_ADDR_LO) bus_rdata = r_q.addr_lo;
        if (bus_addr == OFF_ADDR_HI) bus_rdata = r_q.addr_hi;
        for (int i = 0; i < WORDS; i++) begin
            if (bus_addr == word_off(OFF_WR_BASE, i)) bus_rdata = r_q.wr[i];
            if (bus_addr == word_off(OFF_RD_BASE, i)) bus_rdata = r_q.rd[i];
        end
        if (bus_addr == OFF_CTRL) begin
            bus_rdata[CTL_EN]   = r_q.en;
            bus_rdata[CTL_GO]   = r_q.start;
            bus_rdata[CTL_WR]   = r_q.wsel;
            bus_rdata[CTL_BUSY] = busy;
        end
    end
endmodule

// File: rtl/mta_checker.sv
module mta_checker #(
    parameter int BUSY_CYCLES = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        busy,
    input logic [127:0] rd_line
);
    logic [7:0] blen_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    blen_q <= '0;
        else if (busy) blen_q <= blen_q + 1'b1;
        else           blen_q <= '0;
    end

    p_busy_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (blen_q < 8'(BUSY_CYCLES)));

    p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (blen_q == 8'(BUSY_CYCLES)));

    p_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h90 && bus_wdata[1:0] == 2'b11 && !busy) |=> busy);

    p_no_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h90 && !bus_wdata[0] && !busy) |=> !busy);

    p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(rd_line));
endmodule

bind mem_test_agent mta_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(busy), .rd_line(rd_line)
);

// File: tb/mem_test_agent_test.sv
module mem_test_agent_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        busy;

    int checks = 0;
    int failures = 0;
    logic [127:0] model [256];

    mem_test_agent uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] woff(input logic [7:0] base, input int i);
        return base + 8'(16 * (i >> 1)) + 8'(4 * (i & 1));
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rreg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic poll_idle(input string req);
        logic [31:0] c;
        int n = 0;
        do begin
            rreg(8'h90, c);
            n++;
        end while (c[3] && n < 20);
        if (c[3]) check(req, 1, 0);
    endtask

    task automatic load_wr(input logic [127:0] line);
        for (int i = 0; i < 4; i++) wreg(woff(8'h10, i), line[32*i +: 32]);
    endtask

    task automatic txn(input logic [31:0] addr, input logic w);
        wreg(8'h00, addr);
        wreg(8'h08, 32'h0);
        wreg(8'h90, {29'h0, w, 2'b01});
        wreg(8'h90, {29'h0, w, 2'b11});
        poll_idle("R3");
    endtask

    task automatic get_rd(output logic [127:0] line);
        logic [31:0] d;
        for (int i = 0; i < 4; i++) begin
            rreg(woff(8'h18, i), d);
            line[32*i +: 32] = d;
        end
    endtask

    function automatic logic [127:0] rnd_line();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [127:0] ln, l2;
        void'($urandom(32'd20240517));
        for (int i = 0; i < 256; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rreg(8'h90, d); check("R1 ctrl", d, 0);
        check("R1 busy", busy, 0);
        get_rd(ln); check("R1 rd", ln, 0);
        txn(32'h0000_0AB0, 1'b0); get_rd(ln); check("R1 mem", ln, 0);

        // R9: readback and unmapped offsets
        wreg(8'h08, 32'hDEAD_0001); rreg(8'h08, d); check("R9 addr_hi", d, 32'hDEAD_0001);
        wreg(8'h08, 32'h0);
        rreg(8'h04, d); check("R9 unmapped", d, 0);
        wreg(8'h90, 32'h5); rreg(8'h90, d); check("R9 ctrl bits", d, 32'h5);

        // R4: start without enable
        wreg(8'h90, 32'h6);
        check("R4 busy", busy, 0);
        @(negedge clk); check("R4 busy later", busy, 0);

        // R3 + R5: exact busy window on a write
        ln = rnd_line(); load_wr(ln);
        wreg(8'h00, 32'h0000_0120);
        wreg(8'h90, 32'h5);
        wreg(8'h90, 32'h7);
        for (int k = 0; k < 4; k++) begin
            check("R3 busy high", busy, 1);
            if (k == 0) begin rreg(8'h90, d); check("R3 start set", d[1], 1); end
            else @(negedge clk);
        end
        check("R3 busy low", busy, 0);
        rreg(8'h90, d); check("R3 start cleared", d[1], 0);
        model[8'h12] = ln;
        txn(32'h0000_0128, 1'b0); get_rd(l2); check("R5/R2 line", l2, ln);

        // R5/R6: word placement (word 2 at 0x20 -> bits 95:64)
        load_wr({32'h4, 32'h3, 32'h2, 32'h1});
        txn(32'h0000_0030, 1'b1); model[3] = {32'h4, 32'h3, 32'h2, 32'h1};
        txn(32'h0000_0030, 1'b0);
        rreg(8'h28, d); check("R6 word2 at 0x28", d, 32'h3);
        rreg(8'h1C, d); check("R6 word1 at 0x1C", d, 32'h2);

        // R2: address bits above 11 and below 4 ignored
        txn(32'hFFFF_F03F, 1'b0); get_rd(ln); check("R2 alias", ln, model[3]);

        // R7: second start during busy ignored (would be a write)
        load_wr(rnd_line());
        wreg(8'h00, 32'h0000_0030);
        wreg(8'h90, 32'h1);
        wreg(8'h90, 32'h3);
        wreg(8'h90, 32'h7);
        poll_idle("R7");
        repeat (2) @(negedge clk);
        check("R7 no second txn", busy, 0);
        rreg(8'h90, d); check("R7 write bit kept", d[2], 0);
        txn(32'h0000_0030, 1'b0); get_rd(ln); check("R7 line intact", ln, model[3]);

        // R8: write data changed during busy
        ln = rnd_line(); load_wr(ln);
        wreg(8'h00, 32'h0000_0450);
        wreg(8'h90, 32'h5);
        wreg(8'h90, 32'h7);
        wreg(8'h10, 32'hBAD0_BAD0);
        wreg(8'h24, 32'hBAD1_BAD1);
        poll_idle("R8");
        model[8'h45] = ln;
        txn(32'h0000_0450, 1'b0); get_rd(l2); check("R8 snapshot", l2, ln);

        // R6: read words untouched by a write transaction
        txn(32'h0000_0770, 1'b1);
        get_rd(l2); check("R6 rd hold on write", l2, ln);
        model[8'h77] = {32'hBAD1_BAD1, uut.u_store.rline[95:64] & 32'h0, 32'h0, 32'h0} | 128'h0;
        model[8'h77] = {32'hBAD1_BAD1, ln[95:64], ln[63:32], 32'hBAD0_BAD0};

        // R5/R6 random traffic
        for (int it = 0; it < 40; it++) begin
            logic [7:0] ix = 8'($urandom);
            if ($urandom % 2) begin
                ln = rnd_line(); load_wr(ln);
                txn({20'h0, ix, 4'($urandom)}, 1'b1);
                model[ix] = ln;
            end else begin
                txn({20'($urandom), ix, 4'($urandom)}, 1'b0);
                get_rd(l2); check("R6 random read", l2, model[ix]);
            end
        end
        for (int ix = 0; ix < 256; ix += 17) begin
            txn({20'h0, 8'(ix), 4'h0}, 1'b0);
            get_rd(l2); check("R5 sweep", l2, model[ix]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule